// File: doc/BRIEF.md
# Serial Character Receiver with Mid-Bit Start Qualification

This block turns an asynchronous serial line into parallel characters. It runs from the system clock. A one-clock enable pulse arrives sixteen times per bit period, and the block counts those pulses to find its sampling points. A falling edge on the line does not start a character by itself. The edge only starts a check of the line at the centre of the start bit. If the line has gone high again by then, the edge is discarded and no character is built.

After a valid start, the block collects 5 to 8 data bits, least significant first. It then reads an optional parity bit and a stop bit. The finished character is copied into a holding register, and the error flags are set for that character. A host reads the character through a one-clock read strobe, which clears the ready and overrun indications. Baud-rate generation, transmission and register decoding live outside this block.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, hold_data is 0 and data_ready, overrun_err, parity_err, framing_err and break_det are all 0.
- R2: A falling edge is followed by a line sample on the 8th tick16 pulse. If that sample is high, the edge is dropped: no character completes, and data_ready and hold_data keep their values.
- R3: After a valid start, every following bit is sampled 16 ticks after the one before. There are 5+word_len data bits (word_len 0..3 selects 5..8), taken least significant first. Unused upper bits of hold_data read 0.
- R4: When the stop bit is sampled, the received character is loaded into hold_data, and data_ready is 1 from the next clock.
- R5: With par_en=1, one parity bit follows the data bits. With par_stick=0, par_even=1 expects an even total count of ones over data plus parity, and par_even=0 expects an odd count. With par_stick=1, the expected parity bit is the inverse of par_even. A mismatch sets parity_err. With par_en=0, no parity bit is read and parity_err is 0.
- R6: A stop bit sampled low sets framing_err.
- R7: break_det is set when the data bits, the parity bit (if enabled) and the stop bit all sample low. A break also sets framing_err.
- R8: If a character completes while data_ready is still 1, overrun_err is set and the new character replaces hold_data.
- R9: A one-clock rd_hold pulse clears data_ready and overrun_err on the next clock.
- R10: parity_err, framing_err and break_det are reloaded at every completed character, so they describe the latest character only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-clock pulse at 16 times the bit rate |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select (stick value inverted) |
| par_stick | input | 1 | Forced parity bit value |
| rd_hold | input | 1 | Read strobe for the holding register |
| hold_data | output | 8 | Last received character |
| data_ready | output | 1 | Unread character present |
| overrun_err | output | 1 | Character lost to overwrite |
| parity_err | output | 1 | Parity mismatch on last character |
| framing_err | output | 1 | Stop bit low on last character |
| break_det | output | 1 | Whole frame low on last character |

## Verification
The line passes through a two-stage synchronizer, so the receiver sees each change on rx_line two clocks late. The stop bit is sampled on the 8th tick of the stop-bit period. The holding register and every status flag then change on the clock edge after that sample. The bench holds each bit for a full 16 ticks and returns the line to idle. It reads outputs only after the stop period has ended plus an idle gap, which is well after that edge. A read strobe lasts one clock, and its effect is checked on the following falling clock edge. For the discarded start, the line goes high again after 4 ticks. The bench then waits far beyond the 8th tick before confirming that nothing changed.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;

  // number of data bits for a word-length code
  function automatic logic [3:0] data_bits(input logic [1:0] wl);
    return {2'b00, wl} + 4'd5;
  endfunction

  // expected parity bit for the data of the current word length
  function automatic logic parity_expect(input logic [7:0] d, input logic [1:0] wl,
                                         input logic even, input logic stick);
    logic x;
    x = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < data_bits(wl)) x = x ^ d[i];
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_s,
  input  logic       rx_fall,
  input  logic       tick16,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       start_ok,
  output logic       start_false,
  output logic       char_done,
  output logic [7:0] char_data,
  output logic       par_bad,
  output logic       stop_low,
  output logic       all_low
);
  localparam int CW  = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e   state;
  logic [CW-1:0] tcnt;
  logic [3:0]  bit_idx;
  logic [7:0]  shreg;
  logic        par_smp;
  logic        zero_acc;

  logic [3:0] nd;
  logic [3:0] stop_idx;
  logic       mid_now;
  logic       sample_now;

  assign nd         = data_bits(word_len);
  assign stop_idx   = nd + {3'b000, par_en};
  assign mid_now    = (state == ST_START) && tick16 && (tcnt == MID);
  assign start_ok   = mid_now && !rx_s;
  assign start_false = mid_now && rx_s;
  assign sample_now = (state == ST_BITS) && tick16 && (tcnt == LAST);
  assign char_done  = sample_now && (bit_idx == stop_idx);
  assign char_data  = shreg;
  assign par_bad    = par_en && (par_smp != parity_expect(shreg, word_len, par_even, par_stick));
  assign stop_low   = ~rx_s;
  assign all_low    = zero_acc & ~rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_smp  <= 1'b0;
      zero_acc <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rx_fall) begin
            state <= ST_START;
            tcnt  <= '0;
          end
        end
        ST_START: begin
          if (start_ok) begin
            state    <= ST_BITS;
            tcnt     <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            zero_acc <= 1'b1;
          end else if (start_false) begin
            state <= ST_IDLE;
          end else if (tick16) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (sample_now) begin
            tcnt    <= '0;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx < nd) begin
              shreg[bit_idx[2:0]] <= rx_s;
              zero_acc <= zero_acc & ~rx_s;
            end else if (bit_idx != stop_idx) begin
              par_smp  <= rx_s;
              zero_acc <= zero_acc & ~rx_s;
            end else begin
              state <= ST_IDLE;
            end
          end else if (tick16) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_done,
  input  logic [DW-1:0] char_data,
  input  logic          par_bad,
  input  logic          stop_low,
  input  logic          all_low,
  input  logic          rd_hold,
  output logic [DW-1:0] hold_data,
  output logic          data_ready,
  output logic          overrun_err,
  output logic          parity_err,
  output logic          framing_err,
  output logic          break_det
);
  logic lost;
  assign lost = char_done && data_ready && !rd_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data   <= '0;
      data_ready  <= 1'b0;
      overrun_err <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      break_det   <= 1'b0;
    end else begin
      if (char_done) begin
        hold_data   <= char_data;
        data_ready  <= 1'b1;
        overrun_err <= lost | (overrun_err & ~rd_hold);
        parity_err  <= par_bad;
        framing_err <= stop_low;
        break_det   <= all_low;
      end else if (rd_hold) begin
        data_ready  <= 1'b0;
        overrun_err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OSR        = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       rd_hold,
  output logic [7:0] hold_data,
  output logic       data_ready,
  output logic       overrun_err,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_det
);
  logic       rx_s, rx_fall;
  logic       start_ok, start_false, char_done;
  logic [7:0] char_data;
  logic       par_bad, stop_low, all_low;

  uart_rx_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s), .fall(rx_fall)
  );

  uart_rx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .rx_fall(rx_fall), .tick16(tick16),
    .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .start_ok(start_ok), .start_false(start_false), .char_done(char_done),
    .char_data(char_data), .par_bad(par_bad), .stop_low(stop_low), .all_low(all_low)
  );

  uart_rx_hold #(.DW(8)) u_hold (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
    .par_bad(par_bad), .stop_low(stop_low), .all_low(all_low), .rd_hold(rd_hold),
    .hold_data(hold_data), .data_ready(data_ready), .overrun_err(overrun_err),
    .parity_err(parity_err), .framing_err(framing_err), .break_det(break_det)
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       char_done,
  input logic       start_ok,
  input logic       start_false,
  input logic       rd_hold,
  input logic [7:0] hold_data,
  input logic       data_ready,
  input logic       overrun_err,
  input logic       framing_err,
  input logic       break_det
);
  a_r4_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> data_ready);

  a_r2_false_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_false && !rd_hold |=> $stable(data_ready) && $stable(hold_data));

  a_r2_start_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && char_done));

  a_r7_break_is_framing: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> framing_err);

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && data_ready && !rd_hold |=> overrun_err);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold && !char_done |=> !data_ready && !overrun_err);

  a_r10_hold_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done |=> $stable(hold_data));
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .char_done(char_done), .start_ok(start_ok),
  .start_false(start_false), .rd_hold(rd_hold), .hold_data(hold_data),
  .data_ready(data_ready), .overrun_err(overrun_err), .framing_err(framing_err),
  .break_det(break_det)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic       rd_hold = 1'b0;
  logic [7:0] hold_data;
  logic       data_ready, overrun_err, parity_err, framing_err, break_det;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int tdiv = 0;

  localparam int BITCLK = 64; // 16 ticks x 4 clocks

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rd_hold(rd_hold), .hold_data(hold_data), .data_ready(data_ready),
    .overrun_err(overrun_err), .parity_err(parity_err), .framing_err(framing_err),
    .break_det(break_det)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] len_mask(input logic [1:0] wl);
    return 8'((16'd1 << (5 + int'(wl))) - 1);
  endfunction

  function automatic logic ref_parity(input logic [7:0] d, input logic [1:0] wl,
                                      input logic ev, input logic st);
    int ones;
    ones = $countones(d & len_mask(wl));
    if (st) return ev ? 1'b0 : 1'b1;
    if (ev) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic hold_line(input logic v, input int clocks);
    rx_line = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_v);
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < 5 + int'(word_len); i++) hold_line(d[i], BITCLK);
    if (par_en) hold_line(ref_parity(d, word_len, par_even, par_stick) ^ flip_par, BITCLK);
    hold_line(stop_v, BITCLK);
    hold_line(1'b1, 24);
  endtask

  task automatic read_hold;
    rd_hold = 1'b1;
    @(negedge clk);
    rd_hold = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'hFF; pats[3] = 8'h13;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hold", hold_data, 8'h00);
    check("R1 flags", {3'b0, data_ready, overrun_err, parity_err, framing_err, break_det}, 8'h00);
    hold_line(1'b1, 40);

    // R3 R4 R5 R10 sweep: word lengths x parity modes x patterns
    for (int wl = 0; wl < 4; wl++) begin
      for (int m = 0; m < 5; m++) begin
        for (int p = 0; p < 4; p++) begin
          word_len  = 2'(wl);
          par_en    = (m != 0);
          par_even  = (m == 2) || (m == 4);
          par_stick = (m >= 3);
          send_frame(pats[p], 1'b0, 1'b1);
          check("R4 ready", {7'b0, data_ready}, 8'h01);
          check("R3 data", hold_data, pats[p] & len_mask(2'(wl)));
          check("R5 parity ok", {7'b0, parity_err}, 8'h00);
          check("R10 flags clean", {5'b0, framing_err, break_det, overrun_err}, 8'h00);
          read_hold();
          check("R9 read clears", {7'b0, data_ready}, 8'h00);
        end
      end
    end

    // R5 bad parity: even, odd, stick
    word_len = 2'd3;
    for (int m = 1; m < 5; m++) begin
      par_en = 1'b1; par_even = (m == 2) || (m == 4); par_stick = (m >= 3);
      send_frame(8'h6C, 1'b1, 1'b1);
      check("R5 parity error", {7'b0, parity_err}, 8'h01);
      check("R5 data kept", hold_data, 8'h6C);
      read_hold();
    end

    // R10 next good character clears parity flag
    send_frame(8'h6C, 1'b0, 1'b1);
    check("R10 parity cleared", {7'b0, parity_err}, 8'h00);
    read_hold();

    // R6 framing error without break
    par_en = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b0);
    check("R6 framing", {6'b0, framing_err, break_det}, 8'h02);
    read_hold();

    // R7 break with parity enabled (even parity of zero is 0)
    par_en = 1'b1; par_even = 1'b1; par_stick = 1'b0;
    send_frame(8'h00, 1'b0, 1'b0);
    check("R7 break", {6'b0, framing_err, break_det}, 8'h03);
    read_hold();
    // R7 only the parity bit high: not a break
    send_frame(8'h00, 1'b1, 1'b0);
    check("R7 not break", {6'b0, framing_err, break_det}, 8'h02);
    read_hold();

    // R8 overrun
    par_en = 1'b0;
    send_frame(8'h11, 1'b0, 1'b1);
    check("R8 no overrun yet", {7'b0, overrun_err}, 8'h00);
    send_frame(8'h22, 1'b0, 1'b1);
    check("R8 overrun", {7'b0, overrun_err}, 8'h01);
    check("R8 replaced", hold_data, 8'h22);
    read_hold();
    check("R9 overrun cleared", {6'b0, data_ready, overrun_err}, 8'h00);

    // R2 false start: low for 4 ticks only
    hold_line(1'b0, 16);
    hold_line(1'b1, 3 * BITCLK);
    check("R2 no ready", {7'b0, data_ready}, 8'h00);
    check("R2 hold kept", hold_data, 8'h22);
    // R2 receiver usable after a discarded edge
    send_frame(8'h9E, 1'b0, 1'b1);
    check("R2 next frame", hold_data, 8'h9E);
    read_hold();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule